// File: doc/BRIEF.md
# Single-Step Shifter and Rotator

This block is a purely combinational unit that moves the bits of one operand word by a single place. A 3-bit operation code selects the move:

- leave the word as it is;
- rotate it toward the most significant end or toward the least significant end;
- shift it left, feeding a 0 in at the bottom;
- shift it right, feeding either a 1 or a 0 in at the top.

Every output bit comes from its own small multiplexer. Each multiplexer picks the bit at the same position, the bit one place below, the bit one place above, or a constant fill value.

The block sits in a datapath between a register read and a write-back. It has no clock and no state. The output follows the operand and the operation code directly. The word width is a parameter with a default of 8 bits and a minimum of 2 bits. Two operation codes leave the word unchanged: one is a deliberate second pass code, and the other is a spare code that is defined as pass so that the output is never undefined.

Top module: `bitshift_unit`

## Requirements
- R1: Operation codes 3'b000 and 3'b101 drive data_out equal to data_in.
- R2: The spare operation code 3'b011 also drives data_out equal to data_in.
- R3: Code 3'b001 rotates one place toward the MSB: data_out[i] = data_in[i-1] for i > 0, and data_out[0] = data_in[WIDTH-1].
- R4: Code 3'b110 rotates one place toward the LSB: data_out[i] = data_in[i+1] for i < WIDTH-1, and data_out[WIDTH-1] = data_in[0].
- R5: Code 3'b100 shifts one place toward the MSB: the old MSB is dropped and data_out[0] is 0.
- R6: Code 3'b010 shifts one place toward the LSB: the old bit 0 is dropped and data_out[WIDTH-1] is 1.
- R7: Code 3'b111 shifts one place toward the LSB: the old bit 0 is dropped and data_out[WIDTH-1] is 0.
- R8: The two rotate codes keep the number of set bits in the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| data_in | input | WIDTH | Operand word |
| data_out | output | WIDTH | Moved word |

## Verification
The asymmetric word 8'hB4 tells left moves from right moves. Its fill and wrap results also differ between the shift-right-with-1 code and the rotate-right code.

The word 8'h81 has only its two end bits set, so it separates a wrap from a fill at both ends. All-zeros and all-ones expose the value of each fill bit. The alternating words 8'hAA and 8'h55 expose a move of the wrong distance or in the wrong direction.

Random operands over all eight codes, checked against an independent per-bit model, cover the remaining bit combinations.

// File: rtl/bitshift_unit.sv
module bitshift_unit #(
  parameter int WIDTH = 8
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out
);

  typedef enum logic [1:0] {MV_HOLD, MV_UP, MV_DOWN} move_t;

  move_t move;
  logic  wrap;
  logic  fill;

  always_comb begin
    move = MV_HOLD;
    wrap = 1'b0;
    fill = 1'b0;
    case (op_sel)
      3'b001: begin move = MV_UP;   wrap = 1'b1; end
      3'b100: begin move = MV_UP;   fill = 1'b0; end
      3'b010: begin move = MV_DOWN; fill = 1'b1; end
      3'b110: begin move = MV_DOWN; wrap = 1'b1; end
      3'b111: begin move = MV_DOWN; fill = 1'b0; end
      default: move = MV_HOLD;
    endcase
  end

  logic [WIDTH-1:0] from_low;
  logic [WIDTH-1:0] from_high;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_bottom
      assign from_low[i] = wrap ? data_in[WIDTH-1] : fill;
    end else begin : g_lower
      assign from_low[i] = data_in[i-1];
    end
    if (i == WIDTH-1) begin : g_top
      assign from_high[i] = wrap ? data_in[0] : fill;
    end else begin : g_upper
      assign from_high[i] = data_in[i+1];
    end
    assign data_out[i] = (move == MV_UP)   ? from_low[i]  :
                         (move == MV_DOWN) ? from_high[i] : data_in[i];
  end

  always_comb begin
    if (op_sel == 3'b000 || op_sel == 3'b101)
      assert_pass_R1: assert (data_out == data_in) else $error("pass code altered word");
    if (op_sel == 3'b011)
      assert_spare_R2: assert (data_out == data_in) else $error("spare code altered word");
    if (op_sel == 3'b001)
      assert_rotl_R3: assert (data_out[0] == data_in[WIDTH-1] && data_out[WIDTH-1:1] == data_in[WIDTH-2:0])
        else $error("rotate up wrong");
    if (op_sel == 3'b110)
      assert_rotr_R4: assert (data_out[WIDTH-1] == data_in[0] && data_out[WIDTH-2:0] == data_in[WIDTH-1:1])
        else $error("rotate down wrong");
    if (op_sel == 3'b100)
      assert_shl_fill0_R5: assert (!data_out[0] && data_out[WIDTH-1:1] == data_in[WIDTH-2:0])
        else $error("shift up wrong");
    if (op_sel == 3'b010)
      assert_shr_fill1_R6: assert (data_out[WIDTH-1] && data_out[WIDTH-2:0] == data_in[WIDTH-1:1])
        else $error("shift down fill 1 wrong");
    if (op_sel == 3'b111)
      assert_shr_fill0_R7: assert (!data_out[WIDTH-1] && data_out[WIDTH-2:0] == data_in[WIDTH-1:1])
        else $error("shift down fill 0 wrong");
    if (op_sel == 3'b001 || op_sel == 3'b110)
      assert_rot_ones_R8: assert ($countones(data_out) == $countones(data_in))
        else $error("rotate changed ones count");
  end

endmodule

// File: tb/bitshift_unit_test.sv
module bitshift_unit_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]   op_sel;
  logic [W-1:0] data_in;
  logic [W-1:0] data_out;

  bitshift_unit #(.WIDTH(W)) uut (.op_sel(op_sel), .data_in(data_in), .data_out(data_out));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam int NVEC = 16;
  localparam logic [18:0] VECS [NVEC] = '{
    {3'b000, 8'hB4, 8'hB4}, {3'b001, 8'hB4, 8'h69}, {3'b010, 8'hB4, 8'hDA}, {3'b011, 8'hB4, 8'hB4},
    {3'b100, 8'hB4, 8'h68}, {3'b101, 8'hB4, 8'hB4}, {3'b110, 8'hB4, 8'h5A}, {3'b111, 8'hB4, 8'h5A},
    {3'b000, 8'h81, 8'h81}, {3'b001, 8'h81, 8'h03}, {3'b010, 8'h81, 8'hC0}, {3'b011, 8'h81, 8'h81},
    {3'b100, 8'h81, 8'h02}, {3'b101, 8'h81, 8'h81}, {3'b110, 8'h81, 8'hC0}, {3'b111, 8'h81, 8'h40}
  };

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'b000, 3'b101: return "R1";
      3'b011:         return "R2";
      3'b001:         return "R3";
      3'b110:         return "R4";
      3'b100:         return "R5";
      3'b010:         return "R6";
      default:        return "R7";
    endcase
  endfunction

  function automatic logic [W-1:0] model(input logic [2:0] s, input logic [W-1:0] v);
    logic [W-1:0] r;
    r = v;
    for (int k = 0; k < W; k++) begin
      case (s)
        3'b001: r[k] = (k == 0) ? v[W-1] : v[k-1];
        3'b100: r[k] = (k == 0) ? 1'b0   : v[k-1];
        3'b110: r[k] = (k == W-1) ? v[0] : v[k+1];
        3'b010: r[k] = (k == W-1) ? 1'b1 : v[k+1];
        3'b111: r[k] = (k == W-1) ? 1'b0 : v[k+1];
        default: r[k] = v[k];
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%b in=%h actual=%h expected=%h", req, op_sel, data_in, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [W-1:0] v);
    @(negedge clk);
    op_sel = s;
    data_in = v;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    op_sel = 3'b000;
    data_in = '0;
    #1;
    check("R1 idle", data_out, '0);

    for (int n = 0; n < NVEC; n++) begin
      apply(VECS[n][18:16], VECS[n][15:8]);
      check(req_of(VECS[n][18:16]), data_out, VECS[n][7:0]);
    end

    for (int s = 0; s < 8; s++) begin
      apply(3'(s), 8'h00); check(req_of(3'(s)), data_out, model(3'(s), 8'h00));
      apply(3'(s), 8'hFF); check(req_of(3'(s)), data_out, model(3'(s), 8'hFF));
      apply(3'(s), 8'hAA); check(req_of(3'(s)), data_out, model(3'(s), 8'hAA));
      apply(3'(s), 8'h55); check(req_of(3'(s)), data_out, model(3'(s), 8'h55));
    end

    // R8: rotates keep the ones count
    for (int n = 0; n < 20; n++) begin
      apply((n % 2) ? 3'b001 : 3'b110, 8'($urandom));
      checks++;
      if ($countones(data_out) != $countones(data_in)) begin
        failures++;
        $display("FAIL R8 ones actual=%0d expected=%0d", $countones(data_out), $countones(data_in));
      end
    end

    for (int n = 0; n < 400; n++) begin
      logic [2:0] s;
      logic [W-1:0] v;
      s = 3'($urandom);
      v = 8'($urandom);
      apply(s, v);
      check(req_of(s), data_out, model(s, v));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule